// File: doc/BRIEF.md
# Program/Erase Status Bit Generator

This block sits on the read path of a nonvolatile memory bank. While the bank runs an internal program or erase, reads return status bytes instead of array contents. The host can poll these bytes to learn when the operation ends. Bit 7 carries a completion flag. For a program it is the inverse of the byte being written, and for an erase it reads zero. Bit 6 flips on every read while the operation is running. When the operation finishes, reads return real array contents again.

The block holds its own cycle-count timer, which models how long each operation takes. The program, sector-erase and bank-erase durations are parameters measured in clock cycles. After the timer expires, a short settling window follows. In that window bit 7 already shows its final value but the other bits are not yet trustworthy. A busy output tells the bank arbiter when the bank is occupied. Command decoding and the array itself live outside this block. The block receives a start pulse with an operation code and the latched program byte, and it takes the array's read data as an input.

Top module: `pe_status_gen`

## Requirements
- R1: After reset, `busy_o` is 0 and `rd_data_o` is 0x00.
- R2: When neither busy nor settling, a read strobe `rd_i` makes `rd_data_o` show `array_data_i` after the next clock edge. Without a read strobe, `rd_data_o` holds its value.
- R3: A `start_i` pulse while idle raises `busy_o` on the next edge. `busy_o` then stays high for exactly the duration chosen by `op_i`: 0 gives PROG_CYCLES, 1 gives SECT_CYCLES, and 2 or 3 gives BANK_CYCLES.
- R4: During a program (`op_i`=0), bit 7 of each read is the inverse of bit 7 of the latched program byte.
- R5: During an erase (`op_i`=1, 2 or 3), bit 7 of each read is 0.
- R6: While busy, bit 6 reads 0 on the first read after a start. It inverts on each further read, however many idle clocks lie between the reads.
- R7: While busy, bits 5..0 of each read are 0, whatever `array_data_i` holds.
- R8: A `start_i` pulse while busy is ignored. The duration, the operation type and the latched byte all stay unchanged.
- R9: For SETTLE_CYCLES cycles after busy ends, reads return bits 6..0 as 0. Bit 7 is the true program bit 7 for a program, or 1 for an erase.
- R10: After the settling window, reads return `array_data_i` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for an internal operation |
| op_i | input | 2 | Operation code: 0 program, 1 sector erase, 2/3 bank erase |
| prog_data_i | input | 8 | Byte being programmed, captured at start |
| array_data_i | input | 8 | True array read data |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Internal operation in progress |

## Verification
The bench goes after the last busy cycle and the first cycle after it. A timer that is off by one would show status one read too long or hand back data one read early. It polls with idle gaps between reads, so a bit-6 flop that toggled every clock would break the alternation. It launches a start during busy; if the design accepted it, the erase duration would stretch and bit 7 would change meaning. It also reads inside the settling window for both polarities of the program byte and for erase, and it changes array data while busy, so a leaking data mux would show through on bits 5..0.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OPC_PROG     = 2'd0,
    OPC_SECT     = 2'd1,
    OPC_BANK     = 2'd2,
    OPC_BANK_ALT = 2'd3
  } opc_e;

  // Byte returned while the internal operation runs.
  function automatic logic [BYTE_W-1:0] busy_status(input logic is_erase,
                                                    input logic [BYTE_W-1:0] pdata,
                                                    input logic tog);
    logic b7;
    b7 = is_erase ? 1'b0 : ~pdata[BYTE_W-1];
    return {b7, tog, {(BYTE_W-2){1'b0}}};
  endfunction

  // Byte returned during the settling window: final flag, rest blanked.
  function automatic logic [BYTE_W-1:0] settle_status(input logic is_erase,
                                                      input logic [BYTE_W-1:0] pdata);
    logic b7;
    b7 = is_erase ? 1'b1 : pdata[BYTE_W-1];
    return {b7, {(BYTE_W-1){1'b0}}};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pe_busy_timer.sv
module pe_busy_timer
  import pe_status_pkg::*;
#(
  parameter int PROG_CYCLES   = 20,
  parameter int SECT_CYCLES   = 50,
  parameter int BANK_CYCLES   = 200,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_i,
  input  logic [1:0] op_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       settle_o
);

  localparam int MAXD = max3(PROG_CYCLES, SECT_CYCLES, BANK_CYCLES);
  localparam int CW   = $clog2(MAXD + 1);

  function automatic logic [CW-1:0] load_value(input logic [1:0] op);
    case (op)
      OPC_PROG: return CW'(PROG_CYCLES - 1);
      OPC_SECT: return CW'(SECT_CYCLES - 1);
      default:  return CW'(BANK_CYCLES - 1);
    endcase
  endfunction

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_value(op_i);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  generate
    if (SETTLE_CYCLES > 0) begin : g_settle
      localparam int SW = $clog2(SETTLE_CYCLES + 1);
      logic [SW-1:0] sc_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          sc_q <= '0;
        else if (launch_i)   sc_q <= '0;
        else if (done_o)     sc_q <= SW'(SETTLE_CYCLES);
        else if (sc_q != '0) sc_q <= sc_q - 1'b1;
      end
      assign settle_o = (sc_q != '0);
    end else begin : g_no_settle
      assign settle_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pe_toggle.sv
module pe_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic flip_i,
  output logic tog_o
);

  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (clear_i) tog_q <= 1'b0;
    else if (flip_i)  tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/pe_read_mux.sv
module pe_read_mux
  import pe_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              settle_i,
  input  logic              is_erase_i,
  input  logic [BYTE_W-1:0] pdata_i,
  input  logic              tog_i,
  input  logic [BYTE_W-1:0] array_i,
  output logic [BYTE_W-1:0] rd_data_o
);

  logic [BYTE_W-1:0] sel_w;
  logic [BYTE_W-1:0] rd_q;

  always_comb begin
    if (busy_i)        sel_w = busy_status(is_erase_i, pdata_i, tog_i);
    else if (settle_i) sel_w = settle_status(is_erase_i, pdata_i);
    else               sel_w = array_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_q <= '0;
    else if (rd_i) rd_q <= sel_w;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int PROG_CYCLES   = 20,
  parameter int SECT_CYCLES   = 50,
  parameter int BANK_CYCLES   = 200,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [7:0] prog_data_i,
  input  logic [7:0] array_data_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o
);

  logic       busy_w;
  logic       done_w;
  logic       settle_w;
  logic       launch_w;
  logic       is_erase_w;
  logic       busy_read_w;
  logic       tog_w;
  logic [1:0] op_q;
  logic [7:0] pdata_q;

  // Named events for the checker.
  assign launch_w    = start_i && !busy_w;
  assign is_erase_w  = (op_q != OPC_PROG);
  assign busy_read_w = rd_i && busy_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OPC_PROG;
      pdata_q <= '0;
    end else if (launch_w) begin
      op_q    <= op_i;
      pdata_q <= prog_data_i;
    end
  end

  pe_busy_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .SECT_CYCLES  (SECT_CYCLES),
    .BANK_CYCLES  (BANK_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch_w),
    .op_i    (op_i),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .settle_o(settle_w)
  );

  pe_toggle u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(launch_w),
    .flip_i (busy_read_w),
    .tog_o  (tog_w)
  );

  pe_read_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (rd_i),
    .busy_i    (busy_w),
    .settle_i  (settle_w),
    .is_erase_i(is_erase_w),
    .pdata_i   (pdata_q),
    .tog_i     (tog_w),
    .array_i   (array_data_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy_w;

endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rd_i,
  input logic       busy_o,
  input logic       settle_w,
  input logic       done_w,
  input logic       is_erase_w,
  input logic [7:0] rd_data_o
);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_w && !start_i |=> !busy_o);

  p_erase_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rd_i && is_erase_w |=> !rd_data_o[7]);

  p_toggle_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rd_i) ##1 (busy_o && rd_i) |=> rd_data_o[6] != $past(rd_data_o[6]));

  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rd_i |=> rd_data_o[5:0] == 6'd0);

  p_settle_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_w && !busy_o && rd_i |=> rd_data_o[6:0] == 7'd0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i && $past(rst_n) |=> $stable(rd_data_o));

endmodule

bind pe_status_gen pe_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_i      (rd_i),
  .busy_o    (busy_o),
  .settle_w  (settle_w),
  .done_w    (done_w),
  .is_erase_w(is_erase_w),
  .rd_data_o (rd_data_o)
);

// File: tb/pe_status_gen_test.sv
`timescale 1ns/1ps
module pe_status_gen_test;

  localparam int P_PROG = 20;
  localparam int P_SECT = 50;
  localparam int P_BANK = 200;
  localparam int P_SET  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] prog_data_i = 8'h00;
  logic [7:0] array_data_i = 8'h00;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       busy_o;

  always #2 clk = ~clk;

  pe_status_gen #(
    .PROG_CYCLES(P_PROG), .SECT_CYCLES(P_SECT),
    .BANK_CYCLES(P_BANK), .SETTLE_CYCLES(P_SET)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .prog_data_i(prog_data_i), .array_data_i(array_data_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // Bench model state
  int         t = 0;
  int         nreads = 0;
  bit         active = 0;
  logic [1:0] cur_op = 2'd0;
  logic [7:0] cur_data = 8'h00;

  function automatic int dur(input logic [1:0] op);
    if (op == 2'd0) return P_PROG;
    if (op == 2'd1) return P_SECT;
    return P_BANK;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic start_op(input logic [1:0] op, input logic [7:0] d);
    start_i = 1'b1; op_i = op; prog_data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    cur_op = op; cur_data = d; t = 1; nreads = 0; active = 1;
  endtask

  task automatic start_ignored(input logic [1:0] op, input logic [7:0] d);
    start_i = 1'b1; op_i = op; prog_data_i = d;
    step();
    start_i = 1'b0;
  endtask

  task automatic read_now(input string req);
    logic [7:0] e;
    bit er;
    int n;
    er = (cur_op != 2'd0);
    n  = dur(cur_op);
    if (active && t <= n) begin
      e = {er ? 1'b0 : ~cur_data[7], nreads[0], 6'b0};
      nreads++;
    end else if (active && t <= n + P_SET) begin
      e = {er ? 1'b1 : cur_data[7], 7'b0};
    end else begin
      e = array_data_i;
    end
    exp_q.push_back(e);
    tag_q.push_back(req);
    rd_i = 1'b1;
    step();
    rd_i = 1'b0;
  endtask

  task automatic check_busy(input string req);
    bit e;
    e = active && (t <= dur(cur_op));
    check(req, {7'b0, busy_o}, {7'b0, e});
  endtask

  task automatic wait_until(input int k);
    while (t < k) step();
  endtask

  // Monitor: pop expected read data after each read edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_i) begin
        #1;
        if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data_o, 8'h00);
    check("R1 busy", {7'b0, busy_o}, 8'h00);
    rst_n = 1'b1;
    step();

    // R2 idle read and hold
    array_data_i = 8'h3C;
    read_now("R2 idle read");
    array_data_i = 8'h11;
    repeat (3) step();
    check("R2 hold without read", rd_data_o, 8'h3C);

    // Program 0xA5: bit7 complement is 0
    start_op(2'd0, 8'hA5);
    check_busy("R3 busy after start");
    array_data_i = 8'h7F;
    read_now("R4 R6 R7 first busy read");
    repeat (3) step();
    read_now("R6 second read after gap");
    read_now("R6 third read");
    start_ignored(2'd1, 8'h00);
    read_now("R8 flag after ignored start");
    wait_until(P_PROG);
    check_busy("R3 last busy cycle");
    read_now("R3 read on last busy cycle");
    check_busy("R8 R3 busy ends on program length");
    array_data_i = 8'hA5;
    read_now("R9 settle program");
    wait_until(P_PROG + P_SET + 1);
    read_now("R10 data after settle");

    // Program 0x35: bit7 complement is 1
    start_op(2'd0, 8'h35);
    read_now("R4 inverted flag high");
    read_now("R6 toggle after restart");
    wait_until(P_PROG + 1);
    array_data_i = 8'h35;
    read_now("R9 settle program low flag");
    wait_until(P_PROG + P_SET + 2);
    read_now("R10 data after program");

    // Sector erase
    start_op(2'd1, 8'h5A);
    array_data_i = 8'hC3;
    read_now("R5 erase flag");
    step();
    read_now("R5 R6 erase second read");
    wait_until(P_SECT);
    check_busy("R3 sector last busy");
    step();
    check_busy("R3 sector ends");
    array_data_i = 8'hFF;
    read_now("R9 settle erase");
    wait_until(P_SECT + P_SET + 1);
    read_now("R10 erased data");

    // Bank erase with alternate code
    start_op(2'd3, 8'h00);
    read_now("R5 bank erase flag");
    wait_until(P_BANK);
    check_busy("R3 bank last busy");
    read_now("R7 bank last read");
    check_busy("R3 bank ends");
    wait_until(P_BANK + P_SET + 1);
    array_data_i = 8'hFF;
    read_now("R10 after bank erase");

    repeat (2) step();
    finish_run();
  end

endmodule